// File: doc/BRIEF.md
# LCD Window Timing Generator

This block produces the raster timing for a small LCD panel that shows a 176 x 220 pixel window cut from a 352 x 288 pixel source frame. A divider turns the system clock into one pixel tick every `DIV` clocks. Two counters scan a line of `H_TOTAL` ticks and a frame of `V_TOTAL` lines. From these counters the block derives active-low horizontal and vertical sync, horizontal and vertical data-valid flags, and a level that gates the panel's pixel clock. The horizontal valid flag is raised on every line and the vertical valid flag on every window line.

The window origin comes from two position inputs. They are sampled once per frame, on the final pixel tick of the frame, and clamped so that the window stays inside the source frame. While the scan is inside the source frame, the block presents the frame coordinate of the current pixel to a pixel source. The source answers combinationally with either an 18-bit RGB word or an 8-bit luma byte and an 8-bit chroma byte. The answer is registered together with the timing outputs on the next pixel tick. Every pixel outside the window leaves the block black. In through mode the luma and chroma bytes are packed onto the RGB pins in place of the RGB word.

Top module: `lcd_win_timing`

## Requirements
- R1: A pixel tick occurs every `DIV` clocks, a line lasts `H_TOTAL` ticks, and `hsync_n` is low for the first `H_SYNC` ticks of each line.
- R2: A frame lasts `V_TOTAL` lines, and `vsync_n` is low for the first `V_SYNC` lines of each frame.
- R3: `hvalid` is high for `WIN_W` consecutive ticks starting at line tick `H_START + hpos`, on every line. Because `H_START >= H_SYNC`, it is never high while `hsync_n` is low.
- R4: `vvalid` is high for `WIN_H` consecutive lines starting at line `V_START + vpos`, and is never high while `vsync_n` is low.
- R5: The window position in force during a frame is the value on `hpos_in`/`vpos_in` at the last tick of the previous frame (0 after reset). A change to these inputs during a frame has no effect until the next frame.
- R6: A horizontal position above `FRAME_W - WIN_W` is used as `FRAME_W - WIN_W`. A vertical position above `FRAME_H - WIN_H` is used as `FRAME_H - WIN_H`.
- R7: `pclk_en` is high on window lines from the first window tick until `H_TAIL` ticks after `hvalid` falls, and is low otherwise.
- R8: `rgb_out` is zero whenever `hvalid` and `vvalid` are not both high. Inside the window, in normal mode (`thru_mode` = 0), it equals `rgb_in` as sampled at that tick.
- R9: Inside the window with `thru_mode` = 1, `rgb_out[17:12]` = `y_in[7:2]`, `rgb_out[11:6]` = {`y_in[1:0]`, `c_in[7:4]`}, and `rgb_out[5:0]` = {`c_in[3:0]`, 2'b00}.
- R10: `src_x` = line tick − `H_START` and `src_y` = line − `V_START` while the scan is inside the source frame, and 0 outside it. All other outputs change only on pixel ticks, one tick after the scan state they describe.
- R11: During reset, `hsync_n` and `vsync_n` are 1, and `hvalid`, `vvalid`, `pclk_en` and `rgb_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpos_in | input | clog2(FRAME_W) | Requested horizontal window origin |
| vpos_in | input | clog2(FRAME_H) | Requested vertical window origin |
| thru_mode | input | 1 | 1: pack luma/chroma onto the RGB pins |
| rgb_in | input | 18 | Pixel from the source, normal mode |
| y_in | input | 8 | Luma byte from the source, through mode |
| c_in | input | 8 | Chroma byte from the source, through mode |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| hvalid | output | 1 | Horizontal data-valid flag |
| vvalid | output | 1 | Vertical data-valid flag |
| pclk_en | output | 1 | Pixel clock gate level |
| rgb_out | output | 18 | Pixel to the panel: red [17:12], green [11:6], blue [5:0] |
| src_x | output | clog2(FRAME_W) | Frame column of the pixel being requested |
| src_y | output | clog2(FRAME_H) | Frame line of the pixel being requested |

## Verification
The coordinates `src_x`/`src_y` are combinational from the scan state, so they are due in the same cycle as the tick edge that moves the counters. Every registered output is due on that same edge and carries the decode of the state one tick earlier. The bench's behavioural model advances on the same tick schedule and compares at the falling edge, where that one-tick lag and the non-tick cycles with stable outputs are both visible. Position loading is checked through the coordinate seen when a valid flag first rises, which must equal the latched origin (plus one for the horizontal case).

// File: rtl/lwt_pkg.sv
package lwt_pkg;

   localparam int RGB_W = 18;

   typedef struct packed {
      logic hsync_n;
      logic vsync_n;
      logic hvalid;
      logic vvalid;
      logic pclk_en;
   } lwt_ctl_t;

   localparam lwt_ctl_t CTL_IDLE = '{hsync_n: 1'b1, vsync_n: 1'b1,
                                     hvalid: 1'b0, vvalid: 1'b0, pclk_en: 1'b0};

   // luma on top, chroma below, two zero pad bits in blue LSBs
   function automatic logic [RGB_W-1:0] yc_pack(input logic [7:0] y, input logic [7:0] c);
      return {y, c, 2'b00};
   endfunction

endpackage

// File: rtl/lwt_div.sv
module lwt_div #(
   parameter int DIV = 6
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_nodiv
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign tick      = 1'b1;
      end else begin : g_cnt
         localparam int DW = $clog2(DIV);
         logic [DW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt <= '0;
            else if (cnt == DW'(DIV-1))  cnt <= '0;
            else                         cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == DW'(DIV-1));
      end
   endgenerate
endmodule

// File: rtl/lwt_scan.sv
module lwt_scan #(
   parameter int H_TOTAL = 520,
   parameter int V_TOTAL = 300,
   localparam int HCW = $clog2(H_TOTAL),
   localparam int VCW = $clog2(V_TOTAL)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   output logic [HCW-1:0] h_cnt,
   output logic [VCW-1:0] v_cnt,
   output logic           frame_load
);
   localparam logic [HCW-1:0] H_LAST = HCW'(H_TOTAL-1);
   localparam logic [VCW-1:0] V_LAST = VCW'(V_TOTAL-1);

   logic h_end;
   assign h_end = (h_cnt == H_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt <= '0;
         v_cnt <= '0;
      end else if (tick) begin
         if (h_end) begin
            h_cnt <= '0;
            v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
         end else begin
            h_cnt <= h_cnt + 1'b1;
         end
      end
   end

   assign frame_load = tick && h_end && (v_cnt == V_LAST);
endmodule

// File: rtl/lwt_window.sv
module lwt_window
   import lwt_pkg::*;
#(
   parameter int FRAME_W = 352,
   parameter int FRAME_H = 288,
   parameter int WIN_W   = 176,
   parameter int WIN_H   = 220,
   parameter int H_TOTAL = 520,
   parameter int H_SYNC  = 148,
   parameter int H_START = 150,
   parameter int H_TAIL  = 16,
   parameter int V_TOTAL = 300,
   parameter int V_SYNC  = 12,
   parameter int V_START = 12,
   localparam int HCW = $clog2(H_TOTAL),
   localparam int VCW = $clog2(V_TOTAL),
   localparam int XW  = $clog2(FRAME_W),
   localparam int YW  = $clog2(FRAME_H)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           frame_load,
   input  logic [HCW-1:0] h_cnt,
   input  logic [VCW-1:0] v_cnt,
   input  logic [XW-1:0]  hpos_in,
   input  logic [YW-1:0]  vpos_in,
   output lwt_ctl_t       ctl_nx,
   output logic [XW-1:0]  src_x,
   output logic [YW-1:0]  src_y
);
   localparam int HW1 = HCW + 1;
   localparam int VW1 = VCW + 1;
   localparam logic [XW-1:0] HMAX = XW'(FRAME_W - WIN_W);
   localparam logic [YW-1:0] VMAX = YW'(FRAME_H - WIN_H);

   logic [XW-1:0]  hpos_q, hpos_cl;
   logic [YW-1:0]  vpos_q, vpos_cl;
   logic [HW1-1:0] hx, h_lo, h_hi, h_ce_hi;
   logic [VW1-1:0] vx, v_lo, v_hi;
   logic           h_in_win, v_in_win, h_in_frm, v_in_frm;

   assign hpos_cl = (hpos_in > HMAX) ? HMAX : hpos_in;
   assign vpos_cl = (vpos_in > VMAX) ? VMAX : vpos_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hpos_q <= '0;
         vpos_q <= '0;
      end else if (frame_load) begin
         hpos_q <= hpos_cl;
         vpos_q <= vpos_cl;
      end
   end

   assign hx      = {1'b0, h_cnt};
   assign vx      = {1'b0, v_cnt};
   assign h_lo    = HW1'(H_START) + HW1'(hpos_q);
   assign h_hi    = h_lo + HW1'(WIN_W);
   assign h_ce_hi = h_hi + HW1'(H_TAIL);
   assign v_lo    = VW1'(V_START) + VW1'(vpos_q);
   assign v_hi    = v_lo + VW1'(WIN_H);

   assign h_in_win = (hx >= h_lo) && (hx < h_hi);
   assign v_in_win = (vx >= v_lo) && (vx < v_hi);
   assign h_in_frm = (hx >= HW1'(H_START)) && (hx < HW1'(H_START + FRAME_W));
   assign v_in_frm = (vx >= VW1'(V_START)) && (vx < VW1'(V_START + FRAME_H));

   always_comb begin
      ctl_nx.hsync_n = (hx >= HW1'(H_SYNC));
      ctl_nx.vsync_n = (vx >= VW1'(V_SYNC));
      ctl_nx.hvalid  = h_in_win;
      ctl_nx.vvalid  = v_in_win;
      ctl_nx.pclk_en = v_in_win && (hx >= h_lo) && (hx < h_ce_hi);
   end

   assign src_x = h_in_frm ? XW'(hx - HW1'(H_START)) : '0;
   assign src_y = v_in_frm ? YW'(vx - VW1'(V_START)) : '0;

   AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_load |=> ($stable(hpos_q) && $stable(vpos_q)));          // R5
   AST_POS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (hpos_q <= HMAX) && (vpos_q <= VMAX));                          // R6
endmodule

// File: rtl/lwt_out.sv
module lwt_out
   import lwt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  lwt_ctl_t         ctl_nx,
   input  logic             thru_mode,
   input  logic [RGB_W-1:0] rgb_in,
   input  logic [7:0]       y_in,
   input  logic [7:0]       c_in,
   output lwt_ctl_t         ctl_q,
   output logic [RGB_W-1:0] rgb_q
);
   logic [RGB_W-1:0] rgb_nx;

   always_comb begin
      if (!(ctl_nx.hvalid && ctl_nx.vvalid)) rgb_nx = '0;
      else if (thru_mode)                    rgb_nx = yc_pack(y_in, c_in);
      else                                   rgb_nx = rgb_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_IDLE;
         rgb_q <= '0;
      end else if (tick) begin
         ctl_q <= ctl_nx;
         rgb_q <= rgb_nx;
      end
   end

   AST_BLACK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_q.hvalid && ctl_q.vvalid) |-> (rgb_q == '0));             // R8
   AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(ctl_q) && $stable(rgb_q)));                  // R10
   AST_HSYNC_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q.hsync_n |-> !ctl_q.hvalid);                              // R3
   AST_VSYNC_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q.vsync_n |-> !ctl_q.vvalid);                              // R4
   AST_CLK_COVERS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.hvalid && ctl_q.vvalid) |-> ctl_q.pclk_en);              // R7
endmodule

// File: rtl/lcd_win_timing.sv
module lcd_win_timing
   import lwt_pkg::*;
#(
   parameter int DIV     = 6,
   parameter int FRAME_W = 352,
   parameter int FRAME_H = 288,
   parameter int WIN_W   = 176,
   parameter int WIN_H   = 220,
   parameter int H_TOTAL = 520,
   parameter int H_SYNC  = 148,
   parameter int H_START = 150,
   parameter int H_TAIL  = 16,
   parameter int V_TOTAL = 300,
   parameter int V_SYNC  = 12,
   parameter int V_START = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(FRAME_W)-1:0] hpos_in,
   input  logic [$clog2(FRAME_H)-1:0] vpos_in,
   input  logic                       thru_mode,
   input  logic [17:0]                rgb_in,
   input  logic [7:0]                 y_in,
   input  logic [7:0]                 c_in,
   output logic                       hsync_n,
   output logic                       vsync_n,
   output logic                       hvalid,
   output logic                       vvalid,
   output logic                       pclk_en,
   output logic [17:0]                rgb_out,
   output logic [$clog2(FRAME_W)-1:0] src_x,
   output logic [$clog2(FRAME_H)-1:0] src_y
);
   localparam int HCW = $clog2(H_TOTAL);
   localparam int VCW = $clog2(V_TOTAL);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("DIV must be at least 1");
      end
      if (WIN_W > FRAME_W || WIN_H > FRAME_H) begin : g_bad_win
         $error("window larger than frame");
      end
      if (H_START < H_SYNC || V_START < V_SYNC) begin : g_bad_sync
         $error("valid region must start after sync");
      end
      if (H_START + FRAME_W + H_TAIL > H_TOTAL) begin : g_bad_htot
         $error("line too short for frame plus clock tail");
      end
      if (V_START + FRAME_H > V_TOTAL) begin : g_bad_vtot
         $error("frame period too short");
      end
   endgenerate

   logic           tick, frame_load;
   logic [HCW-1:0] h_cnt;
   logic [VCW-1:0] v_cnt;
   lwt_ctl_t       ctl_nx, ctl_q;

   lwt_div #(.DIV(DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   lwt_scan #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_scan (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .h_cnt(h_cnt), .v_cnt(v_cnt), .frame_load(frame_load)
   );

   lwt_window #(
      .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .WIN_W(WIN_W), .WIN_H(WIN_H),
      .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .H_START(H_START), .H_TAIL(H_TAIL),
      .V_TOTAL(V_TOTAL), .V_SYNC(V_SYNC), .V_START(V_START)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .frame_load(frame_load),
      .h_cnt(h_cnt), .v_cnt(v_cnt), .hpos_in(hpos_in), .vpos_in(vpos_in),
      .ctl_nx(ctl_nx), .src_x(src_x), .src_y(src_y)
   );

   lwt_out u_out (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_nx(ctl_nx),
      .thru_mode(thru_mode), .rgb_in(rgb_in), .y_in(y_in), .c_in(c_in),
      .ctl_q(ctl_q), .rgb_q(rgb_out)
   );

   assign hsync_n = ctl_q.hsync_n;
   assign vsync_n = ctl_q.vsync_n;
   assign hvalid  = ctl_q.hvalid;
   assign vvalid  = ctl_q.vvalid;
   assign pclk_en = ctl_q.pclk_en;
endmodule

// File: tb/test_lcd_win_timing.sv
`timescale 1ns/1ps
module test_lcd_win_timing;
   localparam int DIV = 2;
   localparam int FW = 12, FH = 8, WW = 6, WH = 4;
   localparam int HT = 20, HS = 3, HST = 4, TL = 2;
   localparam int VT = 12, VS = 2, VST = 3;
   localparam int XW = $clog2(FW), YW = $clog2(FH);
   localparam int HMAX = FW - WW, VMAX = FH - WH;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [XW-1:0] hpos_in = '0;
   logic [YW-1:0] vpos_in = '0;
   logic thru_mode = 1'b0;
   logic [17:0] rgb_in = '0;
   logic [7:0] y_in = '0, c_in = '0;
   logic hsync_n, vsync_n, hvalid, vvalid, pclk_en;
   logic [17:0] rgb_out;
   logic [XW-1:0] src_x;
   logic [YW-1:0] src_y;

   always #2.5 clk = ~clk;

   lcd_win_timing #(
      .DIV(DIV), .FRAME_W(FW), .FRAME_H(FH), .WIN_W(WW), .WIN_H(WH),
      .H_TOTAL(HT), .H_SYNC(HS), .H_START(HST), .H_TAIL(TL),
      .V_TOTAL(VT), .V_SYNC(VS), .V_START(VST)
   ) i_lcd_win_timing (
      .clk(clk), .rst_n(rst_n), .hpos_in(hpos_in), .vpos_in(vpos_in),
      .thru_mode(thru_mode), .rgb_in(rgb_in), .y_in(y_in), .c_in(c_in),
      .hsync_n(hsync_n), .vsync_n(vsync_n), .hvalid(hvalid), .vvalid(vvalid),
      .pclk_en(pclk_en), .rgb_out(rgb_out), .src_x(src_x), .src_y(src_y)
   );

   int checks = 0, fails = 0, cyc = 0;
   bit done = 1'b0;

   // behavioural reference
   int  m_div = 0, m_tick = 0, m_h = 0, m_v = 0;
   bit  m_clamped = 1'b0;
   bit  e_hs = 1, e_vs = 1, e_hv = 0, e_vv = 0, e_ce = 0;
   int  e_rgb = 0;
   bit  p_hv = 0, p_vv = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 0; m_tick = 0; m_h = 0; m_v = 0; m_clamped = 0;
         e_hs = 1; e_vs = 1; e_hv = 0; e_vv = 0; e_ce = 0; e_rgb = 0;
      end else begin
         if (m_div == DIV - 1) begin
            int h, v, hlo, vlo;
            h   = m_tick % HT;
            v   = (m_tick / HT) % VT;
            hlo = HST + m_h;
            vlo = VST + m_v;
            e_hs = (h >= HS);
            e_vs = (v >= VS);
            e_hv = (h >= hlo) && (h < hlo + WW);
            e_vv = (v >= vlo) && (v < vlo + WH);
            e_ce = e_vv && (h >= hlo) && (h < hlo + WW + TL);
            if (e_hv && e_vv) e_rgb = thru_mode ? int'({y_in, c_in, 2'b00}) : int'(rgb_in);
            else              e_rgb = 0;
            if (h == HT - 1 && v == VT - 1) begin
               m_clamped = (int'(hpos_in) > HMAX) || (int'(vpos_in) > VMAX);
               m_h = (int'(hpos_in) > HMAX) ? HMAX : int'(hpos_in);
               m_v = (int'(vpos_in) > VMAX) ? VMAX : int'(vpos_in);
            end
            m_tick++;
         end
         m_div = (m_div + 1) % DIV;
      end
   end

   always @(negedge clk) begin
      cyc++;
      if (rst_n && !done) begin
         int h, v, ex, ey;
         h  = m_tick % HT;
         v  = (m_tick / HT) % VT;
         ex = (h >= HST && h < HST + FW) ? h - HST : 0;
         ey = (v >= VST && v < VST + FH) ? v - VST : 0;
         check(hsync_n == e_hs, "R1 hsync_n", hsync_n, e_hs);
         check(vsync_n == e_vs, "R2 vsync_n", vsync_n, e_vs);
         check(hvalid == e_hv, "R3 hvalid", hvalid, e_hv);
         check(vvalid == e_vv, "R4 vvalid", vvalid, e_vv);
         check(pclk_en == e_ce, "R7 pclk_en", pclk_en, e_ce);
         check(int'(rgb_out) == e_rgb, thru_mode ? "R9 rgb_out" : "R8 rgb_out",
               int'(rgb_out), e_rgb);
         check(int'(src_x) == ex, "R10 src_x", int'(src_x), ex);
         check(int'(src_y) == ey, "R10 src_y", int'(src_y), ey);
         // origin in force, seen through the coordinate at valid rise
         if (hvalid && !p_hv)
            check(int'(src_x) == m_h + 1, m_clamped ? "R6 h origin" : "R5 h origin",
                  int'(src_x), m_h + 1);
         if (vvalid && !p_vv)
            check(int'(src_y) == m_v, m_clamped ? "R6 v origin" : "R5 v origin",
                  int'(src_y), m_v);
         p_hv = hvalid;
         p_vv = vvalid;
      end
      rgb_in = 18'(cyc * 2731 + 5);
      y_in   = 8'(cyc * 13 + 1);
      c_in   = 8'(cyc * 7 + 200);
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R11 reset values
      check(hsync_n === 1'b1, "R11 hsync_n", hsync_n, 1);
      check(vsync_n === 1'b1, "R11 vsync_n", vsync_n, 1);
      check(hvalid === 1'b0 && vvalid === 1'b0, "R11 valid", hvalid | vvalid, 0);
      check(pclk_en === 1'b0, "R11 pclk_en", pclk_en, 0);
      check(rgb_out === 18'd0, "R11 rgb_out", int'(rgb_out), 0);
      rst_n = 1'b1;
      repeat (150) @(negedge clk);
      hpos_in = 4'd3; vpos_in = 3'd2;      // R5: mid-frame, takes effect next frame
      repeat (480) @(negedge clk);
      thru_mode = 1'b1;                     // R9
      hpos_in = 4'd15; vpos_in = 3'd7;      // R6: beyond both limits
      repeat (480) @(negedge clk);
      hpos_in = 4'd6; vpos_in = 3'd4;       // exactly at the limits
      thru_mode = 1'b0;
      repeat (480) @(negedge clk);
      hpos_in = 4'd0; vpos_in = 3'd1;
      thru_mode = 1'b1;
      repeat (960) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule